// File: doc/BRIEF.md
# Receive Frame Accept and Status Controller

This block follows the preamble and delimiter checker in an Ethernet receive path. It counts the bytes of every incoming frame, asks the address filter for a verdict once the destination address is complete, and tells the receive FIFO whether the frame should be kept. A keep verdict is only given after a full 64-byte collision window has arrived. Collision runts and frames that the address filter turns down are discarded, so the consumer never sees collision fragments.

While the frame streams in, the controller notes whether the destination is broadcast or multicast and whether the frame has grown beyond the programmed maximum length. It never cuts a long frame short. Instead it raises a babbling-receiver event at the first byte past the limit, and it sets a long-frame flag. When a kept frame ends, the block emits a 32-bit status word (eight flags plus the byte count) together with a descriptor write that marks the buffer as last-in-frame and no longer empty. A frame-received event follows. Both events are held for software until written back with ones, and each one produces a one-cycle interrupt pulse when its mask bit is set.

A promiscuous input lets frames that missed the address filter be kept; these carry the miss flag in their status word.

Top module: `rx_frame_ctrl`

## Requirements
- R1: A frame begins with a byte that has `rx_sof` set and ends with the byte that has `rx_eof` set. Bytes that arrive with no frame open are ignored: they cause no address request, no accept, no reject and no status word.
- R2: `addr_req` pulses for one cycle in the cycle after the 6th byte of a frame is taken. An `addr_done` pulse is honoured only while such a request is pending, with `addr_hit`=1 meaning a match. A frame of fewer than 6 bytes makes no request.
- R3: `fifo_accept` pulses exactly once per frame, in the cycle after the byte that brings the count to max(64, byte on which the verdict arrived). This happens only when the verdict is a match or `prom_en`=1. With `prom_en`=1 and no verdict at all, it pulses after the last byte of a frame of at least 64 bytes.
- R4: A frame that ends with fewer than 64 bytes, or that ends without an accept, gets one `fifo_reject` pulse after its last byte. A frame with no verdict counts as an address miss. Accept and reject never pulse together.
- R5: One cycle after a kept frame ends, `stat_valid` pulses with `stat_word` = {8'b0, M, BC, MC, LG, NO, CR, OV, TR, length[15:0]}, where M is bit 23 and TR is bit 16. In that same cycle `desc_wr`=1, `desc_last`=1 and `desc_empty`=0. A rejected frame produces no status word.
- R6: BC (bit 22) is set when all six destination bytes are 0xFF. MC (bit 21) is set when bit 0 of the first byte is 1 and BC is clear.
- R7: A frame longer than `max_len` is not truncated: its full length is reported and LG (bit 20) is set. A babbling-receiver event (event bit 1) is raised once per frame.
- R8: NO, CR, OV and TR (bits 19 to 16) copy `rx_dribble`, `rx_crc_err`, `rx_overrun` and `rx_trunc` as sampled with the last byte.
- R9: `irq_frame` pulses for one cycle together with `stat_valid` when `irq_mask[0]`=1. `irq_babble` pulses for one cycle, one cycle after the babble event, when `irq_mask[1]`=1. A masked event produces no pulse.
- R10: `ev_frame` and `ev_babble` hold once set, whatever the mask. They clear only when a 1 is written to the matching bit of `ev_clr` (bit 0 for frame, bit 1 for babble). A new event in the same cycle wins over the clear.
- R11: M (bit 23) is set in a kept frame's status word when the frame was kept through `prom_en` without an address match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_data | input | 8 | Received byte |
| rx_dribble | input | 1 | Non-octet ending, sampled with last byte |
| rx_crc_err | input | 1 | CRC error, sampled with last byte |
| rx_overrun | input | 1 | FIFO overrun, sampled with last byte |
| rx_trunc | input | 1 | Truncation, sampled with last byte |
| addr_req | output | 1 | Request for an address verdict |
| addr_done | input | 1 | Address verdict strobe |
| addr_hit | input | 1 | Address verdict: 1 = match |
| prom_en | input | 1 | Keep frames that miss the filter |
| max_len | input | 16 | Maximum frame length in bytes |
| irq_mask | input | 2 | Interrupt enables: bit 0 frame, bit 1 babble |
| ev_clr | input | 2 | Write-one-to-clear for the event bits |
| fifo_accept | output | 1 | Keep-frame pulse to the FIFO |
| fifo_reject | output | 1 | Drop-frame pulse to the FIFO |
| stat_valid | output | 1 | Status word strobe |
| stat_word | output | 32 | Frame status word |
| desc_wr | output | 1 | Descriptor update strobe |
| desc_last | output | 1 | Last-in-frame value for the descriptor |
| desc_empty | output | 1 | Empty value for the descriptor |
| irq_frame | output | 1 | Frame-received interrupt pulse |
| irq_babble | output | 1 | Babbling-receiver interrupt pulse |
| ev_frame | output | 1 | Held frame-received event |
| ev_babble | output | 1 | Held babbling-receiver event |

## Verification
The hardest case to reach is a frame whose keep decision is not set by the 64-byte window. This happens when the address verdict arrives late, when it never arrives, or when it is a miss that promiscuous mode overrides. In each of these cases the accept pulse moves to a different byte, and the miss flag changes. The stimulus therefore sweeps frame lengths just below, on and just above the window and the address-request point. Each length is crossed with verdicts given right after the request, given at byte 70, given as a miss, or never given. Each of those runs with and without promiscuous mode, under four destination patterns (including one that differs from broadcast only in its sixth byte) and three maximum lengths that place the long-frame limit on either side of the frame.

// File: rtl/rx_frame_pkg.sv
package rx_frame_pkg;

    // Flag field of the status word, most significant first (bits 23..16).
    typedef struct packed {
        logic miss;
        logic bcast;
        logic mcast;
        logic longf;
        logic nonoct;
        logic crc;
        logic ovr;
        logic trunc;
    } rx_flags_t;

    localparam int FLAG_W = $bits(rx_flags_t);

    // Values presented to the buffer descriptor on completion.
    typedef struct packed {
        logic wr;
        logic last;
        logic empty;
    } desc_upd_t;

endpackage

// File: rtl/rx_frame_track.sv
module rx_frame_track
    import rx_frame_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 8,
    parameter int ADDR_BYTES = 6,
    parameter int WIN_BYTES  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_dribble,
    input  logic              in_crc,
    input  logic              in_ovr,
    input  logic              in_trunc,
    input  logic              addr_done,
    input  logic              addr_hit,
    input  logic              prom_en,
    input  logic [LEN_W-1:0]  max_len,
    output logic [LEN_W-1:0]  byte_cnt,
    output logic              addr_req,
    output logic              acc_p,
    output logic              rej_p,
    output logic              done_p,
    output logic              babble_p,
    output rx_flags_t         fin_flags,
    output logic [LEN_W-1:0]  fin_len
);

    localparam logic [LEN_W-1:0] CNT_MAX = '1;
    localparam logic [LEN_W-1:0] ADR_CNT = LEN_W'(ADDR_BYTES);
    localparam logic [LEN_W-1:0] WIN_CNT = LEN_W'(WIN_BYTES);

    typedef struct packed {
        logic             active;
        logic [LEN_W-1:0] cnt;
        logic             bc;
        logic             mc;
        logic             pend;
        logic             dec;
        logic             miss;
        logic             sent;
        logic             lg;
        logic             areq;
        logic             acc;
        logic             rej;
        logic             done;
        logic             bab;
        rx_flags_t        fin;
        logic [LEN_W-1:0] flen;
    } trk_t;

    trk_t st_d, st_q;
    logic byte_ok, eof_now, dec_e, miss_e;

    always_comb begin
        st_d      = st_q;
        st_d.areq = 1'b0;
        st_d.acc  = 1'b0;
        st_d.rej  = 1'b0;
        st_d.done = 1'b0;
        st_d.bab  = 1'b0;
        eof_now   = 1'b0;
        byte_ok   = in_valid && (in_sof || st_q.active);

        // Address verdict is honoured only while a request is outstanding.
        if (st_q.pend && addr_done) begin
            st_d.pend = 1'b0;
            st_d.dec  = 1'b1;
            st_d.miss = !addr_hit;
        end

        if (byte_ok) begin
            if (in_sof) begin
                st_d.active = 1'b1;
                st_d.cnt    = LEN_W'(1);
                st_d.bc     = (in_data == '1);
                st_d.mc     = in_data[0];
                st_d.pend   = 1'b0;
                st_d.dec    = 1'b0;
                st_d.miss   = 1'b0;
                st_d.sent   = 1'b0;
                st_d.lg     = 1'b0;
            end else begin
                // Saturating byte count.
                st_d.cnt = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + LEN_W'(1);
                if (st_q.cnt < ADR_CNT) begin
                    st_d.bc = st_q.bc && (in_data == '1);
                end
            end
            if (st_d.cnt == ADR_CNT) begin
                st_d.areq = 1'b1;
                st_d.pend = 1'b1;
            end
            if ((st_d.cnt > max_len) && !st_d.lg) begin
                st_d.lg  = 1'b1;
                st_d.bab = 1'b1;
            end
            eof_now = in_eof;
        end

        // A frame that ends without a verdict is treated as an address miss.
        dec_e  = st_d.dec || eof_now;
        miss_e = st_d.miss || (eof_now && !st_d.dec);

        if (st_d.active && !st_d.sent && (st_d.cnt >= WIN_CNT) && dec_e
            && (!miss_e || prom_en)) begin
            st_d.acc  = 1'b1;
            st_d.sent = 1'b1;
        end

        if (eof_now) begin
            st_d.active = 1'b0;
            st_d.pend   = 1'b0;
            if (st_d.sent) begin
                st_d.done       = 1'b1;
                st_d.flen       = st_d.cnt;
                st_d.fin.miss   = miss_e;
                st_d.fin.bcast  = st_d.bc;
                st_d.fin.mcast  = st_d.mc && !st_d.bc;
                st_d.fin.longf  = st_d.lg;
                st_d.fin.nonoct = in_dribble;
                st_d.fin.crc    = in_crc;
                st_d.fin.ovr    = in_ovr;
                st_d.fin.trunc  = in_trunc;
            end else begin
                st_d.rej = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign byte_cnt  = st_q.cnt;
    assign addr_req  = st_q.areq;
    assign acc_p     = st_q.acc;
    assign rej_p     = st_q.rej;
    assign done_p    = st_q.done;
    assign babble_p  = st_q.bab;
    assign fin_flags = st_q.fin;
    assign fin_len   = st_q.flen;

endmodule

// File: rtl/rx_status_pack.sv
module rx_status_pack
    import rx_frame_pkg::*;
#(
    parameter int LEN_W  = 16,
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done_p,
    input  rx_flags_t         fin_flags,
    input  logic [LEN_W-1:0]  fin_len,
    output logic              stat_valid,
    output logic [STAT_W-1:0] stat_word,
    output desc_upd_t         desc
);

    localparam int PAD_W = STAT_W - FLAG_W - LEN_W;

    typedef struct packed {
        logic              vld;
        logic [STAT_W-1:0] word;
        desc_upd_t         desc;
    } sp_t;

    sp_t sp_d, sp_q;

    always_comb begin
        sp_d            = sp_q;
        sp_d.vld        = done_p;
        sp_d.desc.wr    = done_p;
        sp_d.desc.last  = done_p;
        sp_d.desc.empty = 1'b0;
        if (done_p) begin
            sp_d.word = {{PAD_W{1'b0}}, fin_flags, fin_len};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else begin
            sp_q <= sp_d;
        end
    end

    assign stat_valid = sp_q.vld;
    assign stat_word  = sp_q.word;
    assign desc       = sp_q.desc;

endmodule

// File: rtl/rx_irq_unit.sv
module rx_irq_unit #(
    parameter int N_EV = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EV-1:0] ev_set,
    input  logic [N_EV-1:0] ev_clr,
    input  logic [N_EV-1:0] mask,
    output logic [N_EV-1:0] ev_bits,
    output logic [N_EV-1:0] irq
);

    typedef struct packed {
        logic [N_EV-1:0] ev;
        logic [N_EV-1:0] irq;
    } iu_t;

    iu_t iu_d, iu_q;

    always_comb begin
        iu_d = iu_q;
        for (int i = 0; i < N_EV; i++) begin
            // A fresh event overrides a clear in the same cycle.
            iu_d.ev[i]  = ev_set[i] || (iu_q.ev[i] && !ev_clr[i]);
            iu_d.irq[i] = ev_set[i] && mask[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iu_q <= '0;
        end else begin
            iu_q <= iu_d;
        end
    end

    assign ev_bits = iu_q.ev;
    assign irq     = iu_q.irq;

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl
    import rx_frame_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int DATA_W     = 8,
    parameter int ADDR_BYTES = 6,
    parameter int WIN_BYTES  = 64,
    parameter int STAT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_dribble,
    input  logic              rx_crc_err,
    input  logic              rx_overrun,
    input  logic              rx_trunc,
    output logic              addr_req,
    input  logic              addr_done,
    input  logic              addr_hit,
    input  logic              prom_en,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [1:0]        irq_mask,
    input  logic [1:0]        ev_clr,
    output logic              fifo_accept,
    output logic              fifo_reject,
    output logic              stat_valid,
    output logic [STAT_W-1:0] stat_word,
    output logic              desc_wr,
    output logic              desc_last,
    output logic              desc_empty,
    output logic              irq_frame,
    output logic              irq_babble,
    output logic              ev_frame,
    output logic              ev_babble
);

    localparam int N_EV = 2;

    logic [LEN_W-1:0] byte_cnt;
    logic             done_p;
    logic             babble_p;
    rx_flags_t        fin_flags;
    logic [LEN_W-1:0] fin_len;
    desc_upd_t        desc;
    logic [N_EV-1:0]  ev_bits;
    logic [N_EV-1:0]  irq_v;

    rx_frame_track #(
        .LEN_W      (LEN_W),
        .DATA_W     (DATA_W),
        .ADDR_BYTES (ADDR_BYTES),
        .WIN_BYTES  (WIN_BYTES)
    ) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (rx_valid),
        .in_sof     (rx_sof),
        .in_eof     (rx_eof),
        .in_data    (rx_data),
        .in_dribble (rx_dribble),
        .in_crc     (rx_crc_err),
        .in_ovr     (rx_overrun),
        .in_trunc   (rx_trunc),
        .addr_done  (addr_done),
        .addr_hit   (addr_hit),
        .prom_en    (prom_en),
        .max_len    (max_len),
        .byte_cnt   (byte_cnt),
        .addr_req   (addr_req),
        .acc_p      (fifo_accept),
        .rej_p      (fifo_reject),
        .done_p     (done_p),
        .babble_p   (babble_p),
        .fin_flags  (fin_flags),
        .fin_len    (fin_len)
    );

    rx_status_pack #(
        .LEN_W  (LEN_W),
        .STAT_W (STAT_W)
    ) u_stat (
        .clk        (clk),
        .rst_n      (rst_n),
        .done_p     (done_p),
        .fin_flags  (fin_flags),
        .fin_len    (fin_len),
        .stat_valid (stat_valid),
        .stat_word  (stat_word),
        .desc       (desc)
    );

    rx_irq_unit #(
        .N_EV (N_EV)
    ) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev_set  ({babble_p, done_p}),
        .ev_clr  (ev_clr),
        .mask    (irq_mask),
        .ev_bits (ev_bits),
        .irq     (irq_v)
    );

    assign desc_wr    = desc.wr;
    assign desc_last  = desc.last;
    assign desc_empty = desc.empty;
    assign ev_frame   = ev_bits[0];
    assign ev_babble  = ev_bits[1];
    assign irq_frame  = irq_v[0];
    assign irq_babble = irq_v[1];

endmodule

// File: rtl/rx_frame_ctrl_chk.sv
module rx_frame_ctrl_chk #(
    parameter int LEN_W     = 16,
    parameter int WIN_BYTES = 64,
    parameter int STAT_W    = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LEN_W-1:0]  byte_cnt,
    input logic [LEN_W-1:0]  max_len,
    input logic              addr_req,
    input logic              fifo_accept,
    input logic              fifo_reject,
    input logic              stat_valid,
    input logic [STAT_W-1:0] stat_word,
    input logic              desc_wr,
    input logic              desc_last,
    input logic              desc_empty,
    input logic              irq_frame,
    input logic              ev_frame,
    input logic [1:0]        ev_clr
);

    localparam logic [LEN_W-1:0] WIN_CNT = LEN_W'(WIN_BYTES);

    assert_req_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        addr_req |=> !addr_req);

    assert_acc_after_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_accept |-> (byte_cnt >= WIN_CNT));

    assert_acc_rej_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_accept && fifo_reject));

    assert_no_stat_after_rej_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_reject |=> !stat_valid);

    assert_desc_with_stat_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stat_valid |-> (desc_wr && desc_last && !desc_empty));

    assert_long_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_valid && stat_word[20]) |-> (stat_word[LEN_W-1:0] > max_len));

    assert_irq_with_stat_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_frame |-> (stat_valid && ev_frame));

    assert_event_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_frame && !ev_clr[0]) |=> ev_frame);

endmodule

bind rx_frame_ctrl rx_frame_ctrl_chk #(
    .LEN_W     (LEN_W),
    .WIN_BYTES (WIN_BYTES),
    .STAT_W    (STAT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .byte_cnt    (byte_cnt),
    .max_len     (max_len),
    .addr_req    (addr_req),
    .fifo_accept (fifo_accept),
    .fifo_reject (fifo_reject),
    .stat_valid  (stat_valid),
    .stat_word   (stat_word),
    .desc_wr     (desc_wr),
    .desc_last   (desc_last),
    .desc_empty  (desc_empty),
    .irq_frame   (irq_frame),
    .ev_frame    (ev_frame),
    .ev_clr      (ev_clr)
);

// File: tb/test_rx_frame_ctrl.sv
module test_rx_frame_ctrl;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_valid, rx_sof, rx_eof;
    logic [7:0]  rx_data;
    logic        rx_dribble, rx_crc_err, rx_overrun, rx_trunc;
    logic        addr_req, addr_done, addr_hit, prom_en;
    logic [15:0] max_len;
    logic [1:0]  irq_mask, ev_clr;
    logic        fifo_accept, fifo_reject, stat_valid;
    logic [31:0] stat_word;
    logic        desc_wr, desc_last, desc_empty;
    logic        irq_frame, irq_babble, ev_frame, ev_babble;

    always #4 clk = ~clk;

    rx_frame_ctrl i_rx_frame_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_data(rx_data), .rx_dribble(rx_dribble),
        .rx_crc_err(rx_crc_err), .rx_overrun(rx_overrun), .rx_trunc(rx_trunc),
        .addr_req(addr_req), .addr_done(addr_done), .addr_hit(addr_hit),
        .prom_en(prom_en), .max_len(max_len), .irq_mask(irq_mask),
        .ev_clr(ev_clr), .fifo_accept(fifo_accept), .fifo_reject(fifo_reject),
        .stat_valid(stat_valid), .stat_word(stat_word), .desc_wr(desc_wr),
        .desc_last(desc_last), .desc_empty(desc_empty), .irq_frame(irq_frame),
        .irq_babble(irq_babble), .ev_frame(ev_frame), .ev_babble(ev_babble)
    );

    int errors = 0;
    int checks = 0;

    int sent, acc_n, acc_pos, rej_n, stat_n, areq_n, areq_pos, irqf_n, irqb_n, desc_bad;
    logic [31:0] stat_w;

    int lens [7] = '{1, 6, 7, 63, 64, 65, 80};

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Output monitor, sampling 2 ns after each rising edge.
    always @(posedge clk) begin
        #2;
        if (rx_valid) begin
            if (rx_sof) sent = 1;
            else sent++;
        end
        if (fifo_accept) begin acc_n++; acc_pos = sent; end
        if (fifo_reject) rej_n++;
        if (addr_req) begin areq_n++; areq_pos = sent; end
        if (irq_frame) irqf_n++;
        if (irq_babble) irqb_n++;
        if (stat_valid) begin
            stat_n++;
            stat_w = stat_word;
            if (!(desc_wr && desc_last && !desc_empty)) desc_bad++;
        end else if (desc_wr || desc_last) begin
            desc_bad++;
        end
    end

    task automatic clr_mon();
        acc_n = 0; acc_pos = 0; rej_n = 0; stat_n = 0; areq_n = 0;
        areq_pos = 0; irqf_n = 0; irqb_n = 0; desc_bad = 0; stat_w = '0;
    endtask

    function automatic logic [7:0] dest_byte(input int dest, input int k);
        case (dest)
            0: return 8'hFF;
            1: return (k == 0) ? 8'h01 : 8'h5E;
            2: return (k == 0) ? 8'h02 : 8'hFF;
            default: return (k == 5) ? 8'hFE : 8'hFF;
        endcase
    endfunction

    // amode: 0 match at byte index 6, 1 match at byte index 70, 2 miss at 6, 3 none
    task automatic run_frame(input int idx, input int len, input int dest, input int amode,
                             input bit prom, input int ml, input logic [1:0] msk,
                             input logic [3:0] fl);
        int  kdec;
        bit  decided, hit, pass, lg;
        int  exp_pos;
        logic [31:0] exp_w;
        kdec = (amode == 1) ? 70 : 6;
        @(negedge clk);
        prom_en = prom; max_len = 16'(ml); irq_mask = msk; ev_clr = 2'b11;
        @(negedge clk);
        ev_clr = 2'b00;
        @(negedge clk);
        chk(!ev_frame && !ev_babble, "R10 clear", {ev_babble, ev_frame}, 0);
        clr_mon();
        for (int k = 0; k < len; k++) begin
            rx_valid  = 1'b1;
            rx_sof    = (k == 0);
            rx_eof    = (k == len - 1);
            rx_data   = (k < 6) ? dest_byte(dest, k) : 8'((k * 7 + idx) & 255);
            addr_done = (amode != 3) && (k == kdec);
            addr_hit  = (amode < 2);
            {rx_dribble, rx_crc_err, rx_overrun, rx_trunc} = (k == len - 1) ? fl : 4'b0;
            @(negedge clk);
        end
        rx_valid = 0; rx_sof = 0; rx_eof = 0; addr_done = 0; addr_hit = 0;
        {rx_dribble, rx_crc_err, rx_overrun, rx_trunc} = 4'b0;
        repeat (4) @(negedge clk);

        decided = (amode != 3) && (kdec < len);
        hit     = decided && (amode < 2);
        pass    = (len >= 64) && (hit || prom);
        lg      = (len > ml);
        exp_pos = decided ? ((kdec + 1 > 64) ? kdec + 1 : 64) : len;
        exp_w   = {8'b0, !hit, dest == 0, (dest == 1 || dest == 3), lg, fl, 16'(len)};

        chk(areq_n == ((len >= 6) ? 1 : 0), "R2 request count", areq_n, (len >= 6));
        if (len >= 6) chk(areq_pos == 6, "R2 request position", areq_pos, 6);
        chk(acc_n == int'(pass), "R3 accept count", acc_n, pass);
        if (pass) chk(acc_pos == exp_pos, "R3 accept position", acc_pos, exp_pos);
        chk(rej_n == int'(!pass), "R4 reject count", rej_n, !pass);
        chk(stat_n == int'(pass), "R5 status count", stat_n, pass);
        chk(desc_bad == 0, "R5 descriptor fields", desc_bad, 0);
        if (pass) begin
            chk(stat_w[31:19] == exp_w[31:19], "R6 R7 R11 status flags", stat_w, exp_w);
            chk(stat_w[18:16] == exp_w[18:16] && stat_w[19] == exp_w[19],
                "R8 error flags", stat_w, exp_w);
            chk(stat_w[15:0] == exp_w[15:0], "R7 full length", stat_w, exp_w);
        end
        chk(irqf_n == int'(pass && msk[0]), "R9 frame interrupt", irqf_n, pass && msk[0]);
        chk(irqb_n == int'(lg && msk[1]), "R9 babble interrupt", irqb_n, lg && msk[1]);
        chk(ev_frame == pass, "R10 frame event held", ev_frame, pass);
        chk(ev_babble == lg, "R7 babble event", ev_babble, lg);
    endtask

    initial begin
        rst_n = 0; rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_data = 0;
        rx_dribble = 0; rx_crc_err = 0; rx_overrun = 0; rx_trunc = 0;
        addr_done = 0; addr_hit = 0; prom_en = 0; max_len = 16'd1518;
        irq_mask = 2'b11; ev_clr = 2'b00;
        clr_mon();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk({fifo_accept, fifo_reject, stat_valid, desc_wr, irq_frame, irq_babble,
             ev_frame, ev_babble, addr_req} == 9'b0, "R1 reset outputs",
            {fifo_accept, fifo_reject, stat_valid, ev_frame, ev_babble}, 0);
        chk(stat_word == 32'b0, "R5 reset status word", stat_word, 0);

        // R1: bytes with no open frame are ignored.
        clr_mon();
        prom_en = 1; max_len = 16'd2;
        for (int k = 0; k < 80; k++) begin
            rx_valid = 1; rx_data = 8'hFF; rx_eof = (k == 79);
            addr_done = (k == 10); addr_hit = 1;
            @(negedge clk);
        end
        rx_valid = 0; rx_eof = 0; addr_done = 0; addr_hit = 0;
        repeat (4) @(negedge clk);
        chk(areq_n + acc_n + rej_n + stat_n == 0, "R1 idle bytes ignored",
            areq_n + acc_n + rej_n + stat_n, 0);
        chk(!ev_frame && !ev_babble, "R1 idle no events", {ev_babble, ev_frame}, 0);

        begin
            int idx;
            idx = 0;
            for (int li = 0; li < 7; li++)
                for (int am = 0; am < 4; am++)
                    for (int pr = 0; pr < 2; pr++)
                        for (int de = 0; de < 4; de++) begin
                            run_frame(idx, lens[li], de, am, pr[0],
                                      (idx % 3 == 0) ? 64 : ((idx % 3 == 1) ? 70 : 1518),
                                      2'(idx % 4), 4'(idx % 16));
                            idx++;
                        end
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule